// File: doc/BRIEF.md
# Eight-Bit Compare Timer with Clear-on-Match

This block is an 8-bit up-counter paced by a selectable prescaler. It has two compare channels, A and B, and can run in one of two modes. In free-running mode the counter wraps from 255 to 0 and raises an overflow flag when it does. In clear-on-match mode compare channel A sets the length of the period, so the counter counts from 0 up to the compare-A value and then returns to 0. Each compare channel raises a sticky flag. Software clears a flag by writing 1 to its bit, and each flag drives an interrupt line that has its own enable bit.

A compare event is recorded one tick after the counter first shows the compare value. On the tick that follows equality, the flag is set and, in clear-on-match mode, the counter returns to 0. A compare value of N therefore gives a period of N+1 ticks. The overflow flag can never be raised in clear-on-match mode.

A small controller state machine holds the run state. Its states are `ST_STOP` (no ticks), `ST_FREE` (free-running) and `ST_CLEAR` (clear-on-match). A write to the control register is the only transition. From any state it goes to `ST_STOP` if the clock select is invalid, to `ST_CLEAR` if the mode bit is 1, and to `ST_FREE` if the mode bit is 0. The same write restarts the prescaler.

Top module: `ctc_timer`

## Requirements
- R1: After reset the counter reads 0, all flags and interrupt lines are 0, and the counter does not advance.
- R2: Register 0 holds the mode in bit 0 (1 = clear-on-match) and the clock select in bits 3:1. Select codes 1, 2, 3, 4 and 5 give a tick every 1, 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 stop the counter. After the edge that captures a control write, the first tick lands on the edge one division later. The counter changes only on tick edges.
- R3: Flag bit 1 (compare A) is set on the tick whose pre-tick counter value equals compare A (register 1). This is one tick after equality first shows.
- R4: In clear-on-match mode the counter becomes 0 on the tick that sets the compare-A flag. The period is compare A + 1 ticks. With compare A = 0 the counter stays 0.
- R5: In clear-on-match mode the overflow flag (bit 0) is never set. This holds even when a lowered compare value lets the counter run past 255 and wrap.
- R6: In free-running mode the counter wraps from 255 to 0, and the overflow flag is set on that same tick. A compare-A match does not clear the counter.
- R7: Flag bit 2 (compare B, register 2) is set on the tick whose pre-tick counter value equals compare B, in either mode. It never alters the counter.
- R8: Writing register 4 clears each flag whose data bit is 1. If a flag is set on the same edge as its clear, the set wins.
- R9: Each interrupt line equals its flag ANDed with the matching bit of register 3, which uses the same bit positions as the flags.
- R10: A compare value written on an edge is used for the comparison at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 compare A, 2 compare B, 3 interrupt enable, 4 flag clear) |
| wr_data | input | 8 | Register write data |
| count_o | output | 8 | Current counter value |
| flags_o | output | 3 | Sticky flags: bit 0 overflow, bit 1 compare A, bit 2 compare B |
| irq_o | output | 3 | Interrupt requests, same bit order as the flags |

## Verification
A counter that is off by one, or that clears one tick early or late, shows on `count_o` at the very next tick as a wrong value. It also moves the compare-A flag edge by one tick, so sampling every tick against the arithmetic period of compare A + 1 catches it within one period. A wrong run state or prescaler phase shows up either as a counter that moves between tick edges or as a first advance that arrives at the wrong distance from the control write. A spurious overflow in clear-on-match mode stays latched in `flags_o`, so the next sample exposes it.

// File: rtl/ctc_timer_pkg.sv
package ctc_timer_pkg;

    localparam int ADDR_W    = 3;
    localparam int SEL_W     = 3;
    localparam int SHIFT_W   = 4;
    localparam int NUM_FLAGS = 3;

    localparam int FLAG_OVF  = 0;
    localparam int FLAG_CMPA = 1;
    localparam int FLAG_CMPB = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CMPA = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMPB = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_IEN  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd4;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_FREE  = 2'd1,
        ST_CLEAR = 2'd2
    } run_state_e;

    // Clock select code to log2 of the division ratio
    function automatic logic [SHIFT_W-1:0] sel_shift(input logic [SEL_W-1:0] sel);
        logic [SHIFT_W-1:0] s;
        case (sel)
            3'd1:    s = 4'd0;
            3'd2:    s = 4'd3;
            3'd3:    s = 4'd6;
            3'd4:    s = 4'd8;
            3'd5:    s = 4'd10;
            default: s = 4'd0;
        endcase
        return s;
    endfunction

    function automatic logic sel_valid(input logic [SEL_W-1:0] sel);
        return (sel >= 3'd1) && (sel <= 3'd5);
    endfunction

endpackage

// File: rtl/ctc_timer_regs.sv
module ctc_timer_regs
    import ctc_timer_pkg::*;
#(
    parameter int CNT_W = 8
)
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    output logic [CNT_W-1:0]     cmp_a,
    output logic [CNT_W-1:0]     cmp_b,
    output logic [NUM_FLAGS-1:0] ien,
    output logic [NUM_FLAGS-1:0] clr,
    output logic                 ctrl_wr,
    output logic                 ctc_req,
    output logic [SEL_W-1:0]     sel_req
);

    logic wr_cmpa, wr_cmpb, wr_ien, wr_clr;

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
        wr_cmpa = wr_en && (wr_addr == ADDR_CMPA);
        wr_cmpb = wr_en && (wr_addr == ADDR_CMPB);
        wr_ien  = wr_en && (wr_addr == ADDR_IEN);
        wr_clr  = wr_en && (wr_addr == ADDR_CLR);
    end

    assign ctc_req = wr_data[0];
    assign sel_req = wr_data[SEL_W:1];
    assign clr     = wr_clr ? wr_data[NUM_FLAGS-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_a <= '0;
            cmp_b <= '0;
            ien   <= '0;
        end else begin
            if (wr_cmpa) cmp_a <= wr_data;
            if (wr_cmpb) cmp_b <= wr_data;
            if (wr_ien)  ien   <= wr_data[NUM_FLAGS-1:0];
        end
    end

endmodule

// File: rtl/ctc_timer_ctrl.sv
module ctc_timer_ctrl
    import ctc_timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic               ctc_req,
    input  logic [SEL_W-1:0]   sel_req,
    output logic               running,
    output logic               ctc_mode,
    output logic               ps_restart,
    output logic [SHIFT_W-1:0] shift_o
);

    run_state_e state_q, state_nx;

    // Next state: only a control write moves the machine
    always_comb begin
        state_nx = state_q;
        if (ctrl_wr) begin
            if (!sel_valid(sel_req)) state_nx = ST_STOP;
            else if (ctc_req)        state_nx = ST_CLEAR;
            else                     state_nx = ST_FREE;
        end
    end

    // State register and captured division
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
            shift_o <= '0;
        end else begin
            state_q <= state_nx;
            if (ctrl_wr) shift_o <= sel_shift(sel_req);
        end
    end

    // Outputs decoded from the state
    always_comb begin
        running = 1'b0;
        ctc_mode = 1'b0;
        unique case (state_q)
            ST_STOP: begin
                running  = 1'b0;
                ctc_mode = 1'b0;
            end
            ST_FREE: begin
                running  = 1'b1;
                ctc_mode = 1'b0;
            end
            ST_CLEAR: begin
                running  = 1'b1;
                ctc_mode = 1'b1;
            end
            default: begin
                running  = 1'b0;
                ctc_mode = 1'b0;
            end
        endcase
    end

    assign ps_restart = ctrl_wr;

endmodule

// File: rtl/ctc_timer_prescaler.sv
module ctc_timer_prescaler
    import ctc_timer_pkg::*;
#(
    parameter int PS_W = 10
)
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    logic [PS_W-1:0] ps_cnt;
    logic [PS_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ps_cnt <= '0;
        else if (restart) ps_cnt <= '0;
        else if (run)     ps_cnt <= ps_cnt + PS_W'(1);
    end

    // Low 'shift' bits all ones marks the last clock of a division
    assign mask = ~({PS_W{1'b1}} << shift);
    assign tick = run && ((ps_cnt & mask) == mask);

endmodule

// File: rtl/ctc_timer_core.sv
module ctc_timer_core
    import ctc_timer_pkg::*;
#(
    parameter int CNT_W = 8
)
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 ctc_mode,
    input  logic [CNT_W-1:0]     cmp_a,
    input  logic [CNT_W-1:0]     cmp_b,
    input  logic [NUM_FLAGS-1:0] clr,
    output logic [CNT_W-1:0]     count,
    output logic [NUM_FLAGS-1:0] flags
);

    localparam int NUM_CMP = 2;
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_v;
    logic [NUM_CMP-1:0]            hit;
    logic [NUM_FLAGS-1:0]          set_v;
    logic                          at_top;

    assign cmp_v = {cmp_b, cmp_a};

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        assign hit[c] = (count == cmp_v[c]);
    end

    assign at_top = (count == CNT_TOP);

    always_comb begin
        set_v            = '0;
        set_v[FLAG_OVF]  = tick && at_top && !ctc_mode;
        set_v[FLAG_CMPA] = tick && hit[0];
        set_v[FLAG_CMPB] = tick && hit[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            if (ctc_mode && hit[0]) count <= '0;
            else                    count <= count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set_v;
    end

endmodule

// File: rtl/ctc_timer.sv
module ctc_timer
    import ctc_timer_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PS_W  = 10
)
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    output logic [CNT_W-1:0]     count_o,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic [NUM_FLAGS-1:0] irq_o
);

    logic [CNT_W-1:0]     cmp_a, cmp_b;
    logic [NUM_FLAGS-1:0] ien, clr;
    logic                 ctrl_wr, ctc_req;
    logic [SEL_W-1:0]     sel_req;
    logic                 running, ctc_mode, ps_restart, tick;
    logic [SHIFT_W-1:0]   shift;

    ctc_timer_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmp_a(cmp_a), .cmp_b(cmp_b), .ien(ien),
        .clr(clr), .ctrl_wr(ctrl_wr), .ctc_req(ctc_req), .sel_req(sel_req)
    );

    ctc_timer_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctc_req(ctc_req),
        .sel_req(sel_req), .running(running), .ctc_mode(ctc_mode),
        .ps_restart(ps_restart), .shift_o(shift)
    );

    ctc_timer_prescaler #(.PS_W(PS_W)) ps_i (
        .clk(clk), .rst_n(rst_n), .run(running), .restart(ps_restart),
        .shift(shift), .tick(tick)
    );

    ctc_timer_core #(.CNT_W(CNT_W)) core_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctc_mode(ctc_mode),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .clr(clr), .count(count_o),
        .flags(flags_o)
    );

    assign irq_o = flags_o & ien;

endmodule

// File: rtl/ctc_timer_chk.sv
module ctc_timer_chk
    import ctc_timer_pkg::*;
#(
    parameter int CNT_W = 8
)
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic                 ctc,
    input logic [CNT_W-1:0]     cmp_a,
    input logic [NUM_FLAGS-1:0] clr,
    input logic [CNT_W-1:0]     count,
    input logic [NUM_FLAGS-1:0] flags
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !tick) |=> $stable(count));

    // R3
    cmpa_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(flags[FLAG_CMPA])) |-> $past(tick && (count == cmp_a)));

    // R4
    ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctc && (count == cmp_a)) |=> ((count == '0) && flags[FLAG_CMPA]));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctc && !flags[FLAG_OVF]) |=> !flags[FLAG_OVF]);

    // R6
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctc && (count == {CNT_W{1'b1}})) |=> ((count == '0) && flags[FLAG_OVF]));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[FLAG_CMPA] && !(tick && (count == cmp_a))) |=> !flags[FLAG_CMPA]);

endmodule

bind ctc_timer ctc_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctc(ctc_mode), .cmp_a(cmp_a),
    .clr(clr), .count(count_o), .flags(flags_o)
);

// File: tb/ctc_timer_tb_top.sv
module ctc_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] count;
    logic [2:0] flags;
    logic [2:0] irq;

    int errs   = 0;
    int checks = 0;

    always #10 clk = ~clk;

    ctc_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count), .flags_o(flags), .irq_o(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Called at a negedge; the write lands on the next posedge
    task automatic wr(input int addr, input int data);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start(input bit ctc, input int sel, input int a, input int b, input int ien);
        do_reset;
        wr(1, a);
        wr(2, b);
        wr(3, ien);
        wr(0, (sel << 1) | int'(ctc));
    endtask

    task automatic sweep(input bit ctc, input int sel, input int div, input int a,
                         input int b, input int nticks);
        start(ctc, sel, a, b, 7);
        for (int n = 1; n <= nticks; n++) begin
            int ec, ef;
            if (div > 1) begin
                repeat (div - 1) @(negedge clk);
                chk("R2", "count held between ticks", count, ctc ? (n - 1) % (a + 1) : (n - 1) % 256);
            end
            @(negedge clk);
            ec = ctc ? n % (a + 1) : n % 256;
            ef = 0;
            if (!ctc && n >= 256) ef |= 1;
            if (n >= a + 1) ef |= 2;
            if (ctc ? (b <= a && n >= b + 1) : (n >= b + 1)) ef |= 4;
            chk(ctc ? "R4" : "R6", "count", count, ec);
            chk("R5/R6 ovf", "flag0", int'(flags[0]), ef & 1);
            chk("R3", "cmpA flag", int'(flags[1]), (ef >> 1) & 1);
            chk("R7", "cmpB flag", int'(flags[2]), (ef >> 2) & 1);
            chk("R9", "irq all enabled", int'(irq), ef);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        report;
    end

    initial begin
        int a_list[6] = '{0, 1, 2, 5, 45, 254};
        int b_list[3] = '{0, 3, 200};

        // R1 reset state
        do_reset;
        chk("R1", "count", count, 0);
        chk("R1", "flags", int'(flags), 0);
        chk("R1", "irq", int'(irq), 0);
        repeat (5) @(negedge clk);
        chk("R1", "count idle", count, 0);

        // R2 stop codes
        start(1'b0, 0, 5, 5, 7);
        repeat (20) @(negedge clk);
        chk("R2", "sel 0 stopped", count, 0);
        start(1'b0, 6, 5, 5, 7);
        repeat (20) @(negedge clk);
        chk("R2", "sel 6 stopped", count, 0);
        // stop while running: the capturing edge still ticks
        start(1'b0, 1, 100, 100, 7);
        repeat (4) @(negedge clk);
        wr(0, 0);
        chk("R2", "count at stop", count, 5);
        repeat (10) @(negedge clk);
        chk("R2", "count frozen", count, 5);

        // R4 R3 R7 clear-on-match sweep at division 1
        foreach (a_list[i])
            foreach (b_list[j])
                sweep(1'b1, 1, 1, a_list[i], b_list[j], 2 * (a_list[i] + 1) + 3);

        // R6 free-running
        sweep(1'b0, 1, 1, 10, 20, 300);
        sweep(1'b0, 1, 1, 255, 0, 260);

        // R2 divided rates
        sweep(1'b1, 2, 8, 3, 1, 10);
        sweep(1'b0, 3, 64, 2, 4, 6);
        sweep(1'b1, 4, 256, 1, 0, 4);
        sweep(1'b1, 5, 1024, 1, 1, 3);

        // R8 set wins over clear, R9 per-line enable
        start(1'b1, 1, 3, 0, 3'b010);
        repeat (3) @(negedge clk);
        wr(4, 3'b010);
        chk("R8", "set wins over clear", int'(flags[1]), 1);
        chk("R9", "irq cmpA enabled", int'(irq[1]), 1);
        chk("R9", "cmpB flag set", int'(flags[2]), 1);
        chk("R9", "irq cmpB masked", int'(irq[2]), 0);
        wr(4, 3'b010);
        chk("R8", "clear takes", int'(flags[1]), 0);
        chk("R8", "clear leaves cmpB", int'(flags[2]), 1);
        chk("R8", "count after clear", count, 1);
        chk("R9", "irq after clear", int'(irq), 0);

        // R10 compare update used at next tick
        start(1'b1, 1, 9, 200, 7);
        repeat (3) @(negedge clk);
        wr(1, 5);
        chk("R10", "count", count, 4);
        @(negedge clk);
        chk("R10", "count", count, 5);
        chk("R10", "no early flag", int'(flags[1]), 0);
        @(negedge clk);
        chk("R10", "cleared at new value", count, 0);
        chk("R10", "flag at new value", int'(flags[1]), 1);

        // R5 lowered compare lets the counter wrap without overflow
        start(1'b1, 1, 9, 200, 7);
        repeat (7) @(negedge clk);
        wr(1, 3);
        chk("R5", "count", count, 8);
        repeat (247) @(negedge clk);
        chk("R5", "count top", count, 255);
        @(negedge clk);
        chk("R5", "wrapped", count, 0);
        chk("R5", "no overflow", int'(flags[0]), 0);
        chk("R5", "no cmpA yet", int'(flags[1]), 0);
        repeat (3) @(negedge clk);
        chk("R5", "count", count, 3);
        @(negedge clk);
        chk("R4", "clear after wrap", count, 0);
        chk("R3", "flag after wrap", int'(flags[1]), 1);
        chk("R5", "still no overflow", int'(flags[0]), 0);

        report;
    end

endmodule